// File: doc/BRIEF.md
# Processor Built-In Peripheral Port

This block is a six-line bidirectional port that sits inside a processor and answers at the two lowest locations of its address space. Location 0 holds a direction register. Location 1 holds a data register. Each low bit of the two registers belongs to one peripheral line of the same index. A line whose direction bit is set is driven from the matching data bit. A line whose direction bit is clear is left floating and is read back as whatever level the board presents.

The board holds every line up through a weak pull-up. An open-drain pull-down can also force a line low from outside. The block resolves these effects itself and reports a level for each line. Three of the lines steer memory banking: line 0 selects the low ROM area, line 1 the high ROM area, and line 2 chooses between character ROM and I/O. These three lines are exported as separate signals for a banking decoder. Reset turns every line into an input, so all three banking signals come out high and the ROMs are mapped in.

The other three lines serve the tape interface. Line 3 is write data. Line 4 is the sense input, which reads 0 while play is held. Line 5 drives the motor and is active low. Start-up firmware normally writes 0x37 to the data register and 0x2F to the direction register.

Top module: `cpu_io_port`

## Requirements
- R1: While reset is asserted and right after it ends, the direction register reads 0x00 and no line is driven. Every line and all three banking signals then read 1.
- R2: A write to address 0 stores bits 5..0 as the direction register, which takes effect from the next clock. Reading address 0 returns the stored bits in positions 5..0.
- R3: A write to address 1 stores bits 5..0 as the data register, which takes effect from the next clock. It is stored whatever the direction bits are.
- R4: A line whose direction bit is 1 is driven (pin_oe bit = 1). Its level equals its data register bit unless it is pulled low from outside.
- R5: A line whose direction bit is 0 is not driven. Its level is 1 unless it is pulled low from outside, and the stored data bit has no effect.
- R6: Reading address 1 returns the resolved level of lines 5..0 in bits 5..0. This includes an input held low from outside, for example the tape sense line 4 while play is pressed.
- R7: An output line forced low by the external pull-down reads 0 at address 1 and on its level output, even when its data bit is 1.
- R8: Bits 7..6 read 0 at both addresses, and writing 1s to those bits has no effect.
- R9: bank_lo, bank_hi and bank_chr always equal the resolved levels of lines 0, 1 and 2.
- R10: An access to any address other than 0 or 1 sets bus_sel to 0 and bus_rdata to 0x00. A write to such an address changes neither register. The address is fully decoded.
- R11: After the firmware start-up writes (data 0x37, then direction 0x2F), lines 0..3 are driven with levels 1,1,1,0. Line 5 is driven high, so the motor is stopped. Line 4 stays an input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W (16) | Processor address |
| bus_wdata | input | DATA_W (8) | Write data |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_rdata | output | DATA_W (8) | Read data for address 0 or 1, otherwise 0 |
| bus_sel | output | 1 | High when the address is 0 or 1 |
| ext_pull_low | input | 6 | External open-drain pull-down for each line |
| pin_oe | output | 6 | Drive enable for each line |
| pin_level | output | 6 | Resolved level of each line |
| bank_lo | output | 1 | Resolved level of line 0 (low ROM select) |
| bank_hi | output | 1 | Resolved level of line 1 (high ROM select) |
| bank_chr | output | 1 | Resolved level of line 2 (character ROM or I/O select) |

## Verification
The bench pulls lines low from outside in every combination of direction and data bit. A design that read back the data latch instead of the line would hide a forced-low output and a pressed play key. A design that drove undriven lines to the latched value would show 0 where the pull-up must give 1. It also writes all ones to the top two bits and accesses addresses such as 0x0100 and 0x0002. An upper-bit leak or a partial address decode would then show up as stray read data or a corrupted register. The state coming out of reset is checked before any write, because a direction register that did not clear would leave the banking signals low.

// File: rtl/cpu_io_port_pkg.sv
package cpu_io_port_pkg;
    localparam int PORT_LINES = 6;

    typedef logic [PORT_LINES-1:0] line_vec_t;

    typedef struct packed {
        line_vec_t dir;
        line_vec_t dat;
    } port_regs_t;
endpackage

// File: rtl/cpu_io_port_regs.sv
module cpu_io_port_regs
    import cpu_io_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dir_wr,
    input  logic       dat_wr,
    input  line_vec_t  wr_vec,
    output port_regs_t regs_q
);
    port_regs_t regs_d;

    always_comb begin
        regs_d = regs_q;
        if (dir_wr) regs_d.dir = wr_vec;
        if (dat_wr) regs_d.dat = wr_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end
endmodule

// File: rtl/cpu_io_port_pad.sv
module cpu_io_port_pad
    import cpu_io_port_pkg::*;
(
    input  port_regs_t regs,
    input  line_vec_t  ext_low,
    output line_vec_t  oe,
    output line_vec_t  level
);
    for (genvar i = 0; i < PORT_LINES; i++) begin : g_line
        logic drive_val;
        always_comb begin
            oe[i]     = regs.dir[i];
            drive_val = regs.dir[i] ? regs.dat[i] : 1'b1;
            level[i]  = drive_val & ~ext_low[i];
        end
    end
endmodule

// File: rtl/cpu_io_port_decode.sv
module cpu_io_port_decode
    import cpu_io_port_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int DIR_ADDR  = 0,
    parameter int DATA_ADDR = 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  line_vec_t         dir_vec,
    input  line_vec_t         level_vec,
    output logic              hit_dir_wr,
    output logic              hit_dat_wr,
    output logic              sel,
    output logic [DATA_W-1:0] rdata
);
    localparam int PAD_W = DATA_W - PORT_LINES;
    localparam logic [ADDR_W-1:0] DIR_A = ADDR_W'(DIR_ADDR);
    localparam logic [ADDR_W-1:0] DAT_A = ADDR_W'(DATA_ADDR);

    logic hit_dir, hit_dat;

    always_comb begin
        hit_dir    = (addr == DIR_A);
        hit_dat    = (addr == DAT_A);
        sel        = hit_dir | hit_dat;
        hit_dir_wr = we & hit_dir;
        hit_dat_wr = we & hit_dat;
        if (hit_dir) begin
            rdata = {{PAD_W{1'b0}}, dir_vec};
        end else if (hit_dat) begin
            rdata = {{PAD_W{1'b0}}, level_vec};
        end else begin
            rdata = '0;
        end
    end
endmodule

// File: rtl/cpu_io_port.sv
module cpu_io_port
    import cpu_io_port_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int DIR_ADDR  = 0,
    parameter int DATA_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_sel,
    input  logic [5:0]        ext_pull_low,
    output logic [5:0]        pin_oe,
    output logic [5:0]        pin_level,
    output logic              bank_lo,
    output logic              bank_hi,
    output logic              bank_chr
);
    localparam int LO_LINE  = 0;
    localparam int HI_LINE  = 1;
    localparam int CHR_LINE = 2;

    port_regs_t regs_q;
    line_vec_t  level_w, oe_w;
    logic       dir_wr, dat_wr;

    cpu_io_port_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .DIR_ADDR(DIR_ADDR), .DATA_ADDR(DATA_ADDR)
    ) u_decode (
        .addr(bus_addr), .we(bus_we),
        .dir_vec(regs_q.dir), .level_vec(level_w),
        .hit_dir_wr(dir_wr), .hit_dat_wr(dat_wr),
        .sel(bus_sel), .rdata(bus_rdata)
    );

    cpu_io_port_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .dir_wr(dir_wr), .dat_wr(dat_wr),
        .wr_vec(bus_wdata[PORT_LINES-1:0]),
        .regs_q(regs_q)
    );

    cpu_io_port_pad u_pad (
        .regs(regs_q), .ext_low(ext_pull_low),
        .oe(oe_w), .level(level_w)
    );

    always_comb begin
        pin_oe    = oe_w;
        pin_level = level_w;
        bank_lo   = level_w[LO_LINE];
        bank_hi   = level_w[HI_LINE];
        bank_chr  = level_w[CHR_LINE];
    end
endmodule

// File: rtl/cpu_io_port_chk.sv
module cpu_io_port_chk #(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int DIR_ADDR  = 0,
    parameter int DATA_ADDR = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              bus_sel,
    input logic [5:0]        ext_pull_low,
    input logic [5:0]        pin_oe,
    input logic [5:0]        pin_level,
    input logic              bank_lo,
    input logic              bank_hi,
    input logic              bank_chr
);
    localparam logic [ADDR_W-1:0] DIR_A = ADDR_W'(DIR_ADDR);
    localparam logic [ADDR_W-1:0] DAT_A = ADDR_W'(DATA_ADDR);

    // R2
    dir_write_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == DIR_A) |=> (pin_oe == $past(bus_wdata[5:0])));

    // R4
    driven_follows_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == DAT_A) |=>
        (((pin_level ^ $past(bus_wdata[5:0])) & pin_oe & ~ext_pull_low) == 6'd0));

    // R5
    undriven_pulled_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_level | pin_oe | ext_pull_low) == 6'h3F));

    // R7
    forced_low_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_level & ext_pull_low) == 6'd0));

    // R6
    level_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == DAT_A) |-> (bus_rdata[5:0] == pin_level));

    // R8
    upper_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel |-> (bus_rdata[DATA_W-1:6] == '0));

    // R9
    bank_taps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({bank_chr, bank_hi, bank_lo} == pin_level[2:0]));

    // R10
    foreign_addr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |-> (bus_rdata == '0));

    // R10
    foreign_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !bus_sel) |=> $stable(pin_oe));
endmodule

bind cpu_io_port cpu_io_port_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .DIR_ADDR(DIR_ADDR), .DATA_ADDR(DATA_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .bus_sel(bus_sel),
    .ext_pull_low(ext_pull_low), .pin_oe(pin_oe), .pin_level(pin_level),
    .bank_lo(bank_lo), .bank_hi(bank_hi), .bank_chr(bank_chr)
);

// File: tb/cpu_io_port_tb.sv
module cpu_io_port_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = 16'd0;
    logic [7:0]  bus_wdata = 8'd0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_rdata;
    logic        bus_sel;
    logic [5:0]  ext_pull_low = 6'd0;
    logic [5:0]  pin_oe, pin_level;
    logic        bank_lo, bank_hi, bank_chr;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // behavioural reference state
    int m_dir = 0;
    int m_dat = 0;

    always #10 clk = ~clk;

    cpu_io_port u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .bus_sel(bus_sel),
        .ext_pull_low(ext_pull_low), .pin_oe(pin_oe), .pin_level(pin_level),
        .bank_lo(bank_lo), .bank_hi(bank_hi), .bank_chr(bank_chr)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_dir <= 0;
            m_dat <= 0;
        end else if (bus_we) begin
            if (bus_addr == 16'd0) m_dir <= int'(bus_wdata) % 64;
            if (bus_addr == 16'd1) m_dat <= int'(bus_wdata) % 64;
        end
    end

    function automatic int exp_level();
        int v = 0;
        for (int i = 0; i < 6; i++) begin
            int bit_v;
            if (ext_pull_low[i]) bit_v = 0;
            else if ((m_dir >> i) % 2 == 1) bit_v = (m_dat >> i) % 2;
            else bit_v = 1;
            v += bit_v << i;
        end
        return v;
    endfunction

    task automatic check(input string tag, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, expv, $time);
        end
    endtask

    // compare every output against the reference on each falling edge
    always @(negedge clk) begin
        if (!done && $time > 15) begin
            int lv, rd, sl;
            lv = exp_level();
            if (bus_addr == 16'd0) begin rd = m_dir; sl = 1; end
            else if (bus_addr == 16'd1) begin rd = lv; sl = 1; end
            else begin rd = 0; sl = 0; end
            check("R4,R5 pin_oe", int'(pin_oe), m_dir);
            check("R5,R7 pin_level", int'(pin_level), lv);
            check("R9 banks", int'({bank_chr, bank_hi, bank_lo}), lv % 8);
            check("R2,R6,R8,R10 rdata", int'(bus_rdata), rd);
            check("R10 sel", int'(bus_sel), sl);
        end
    end

    task automatic cyc(input logic [15:0] a, input logic [7:0] d, input logic w,
                       input logic [5:0] pl);
        @(posedge clk);
        #1;
        bus_addr = a; bus_wdata = d; bus_we = w; ext_pull_low = pl;
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int seed;
        cyc(16'd0, 8'h00, 1'b0, 6'd0);
        cyc(16'd1, 8'h00, 1'b0, 6'd0);
        @(negedge clk); #1;
        // R1: during reset
        check("R1 oe in reset", int'(pin_oe), 0);
        check("R1 level in reset", int'(pin_level), 8'h3F);
        #5 rst_n = 1'b1;
        cyc(16'd0, 8'h00, 1'b0, 6'd0);
        @(negedge clk); #1;
        check("R1 dir after reset", int'(bus_rdata), 0);
        check("R1 banks after reset", int'({bank_chr, bank_hi, bank_lo}), 7);
        // R11 firmware start-up
        cyc(16'd1, 8'h37, 1'b1, 6'd0);
        cyc(16'd0, 8'h2F, 1'b1, 6'd0);
        cyc(16'd1, 8'h00, 1'b0, 6'd0);
        @(negedge clk); #1;
        check("R11 oe", int'(pin_oe), 8'h2F);
        check("R11 level", int'(pin_level), 8'h37);
        // R6: play pressed on sense input
        cyc(16'd1, 8'h00, 1'b0, 6'h10);
        @(negedge clk); #1;
        check("R6 sense low", int'(bus_rdata), 8'h27);
        // R8: top bits ignored
        cyc(16'd0, 8'hFF, 1'b1, 6'd0);
        cyc(16'd0, 8'h00, 1'b0, 6'd0);
        @(negedge clk); #1;
        check("R8 dir readback", int'(bus_rdata), 8'h3F);
        // R7: drive line 1 high, force it low
        cyc(16'd1, 8'hC2, 1'b1, 6'h02);
        cyc(16'd1, 8'h00, 1'b0, 6'h02);
        @(negedge clk); #1;
        check("R7 forced low read", int'(bus_rdata), 8'h00);
        check("R7 bank_hi", int'(bank_hi), 0);
        // R10: foreign addresses
        cyc(16'h0100, 8'h00, 1'b1, 6'd0);
        cyc(16'h0002, 8'h3F, 1'b1, 6'd0);
        cyc(16'h0101, 8'h3F, 1'b1, 6'd0);
        cyc(16'd0, 8'h00, 1'b0, 6'd0);
        @(negedge clk); #1;
        check("R10 dir kept", int'(bus_rdata), 8'h3F);
        // R3: data stored while all inputs, then R5 undriven high
        cyc(16'd0, 8'h00, 1'b1, 6'd0);
        cyc(16'd1, 8'h15, 1'b1, 6'd0);
        cyc(16'd1, 8'h00, 1'b0, 6'd0);
        @(negedge clk); #1;
        check("R5 all pulled high", int'(bus_rdata), 8'h3F);
        cyc(16'd0, 8'h3F, 1'b1, 6'd0);
        cyc(16'd1, 8'h00, 1'b0, 6'd0);
        @(negedge clk); #1;
        check("R3 data held", int'(bus_rdata), 8'h15);
        // mixed patterns, compared every cycle by the reference
        seed = 32'h1234;
        for (int k = 0; k < 200; k++) begin
            logic [15:0] a;
            seed = seed * 1103515245 + 12345;
            case ((seed >> 16) % 4)
                0: a = 16'd0;
                1: a = 16'd1;
                2: a = 16'd1;
                default: a = 16'(((seed >> 8) % 3) * 16'h0100 + 2);
            endcase
            cyc(a, 8'((seed >> 3) % 256), 1'((seed >> 12) % 2),
                6'((seed >> 20) % 64) & 6'((seed >> 5) % 64));
        end
        cyc(16'd0, 8'h00, 1'b0, 6'd0);
        @(negedge clk); #2;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule